// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Sequencer

This block drives the timing side of an SPI master that can address up to eight devices. For each device it stores a 32-bit timing word and a pair of clock-mode bits. The timing word holds a rate code and three 8-bit cycle counts: select setup, select hold, and the quiet gap after release. A transfer is started with a one-cycle `start` pulse that names a device and a bit count. The block then pulls that device's active-low select, waits the setup count, and produces two serial clock edges per bit. It then waits the hold count, releases the select, and waits the gap count before accepting the next start.

The serial clock is derived from the functional clock through an 8-bit phase accumulator that adds the rate code every cycle. Each carry out of the accumulator flips the serial clock, so the bit rate is the functional clock times code/512. Alongside each clock edge the block raises a one-cycle launch or capture strobe, chosen by the device's phase bit, so that an external shift register knows when to drive and when to sample. While idle, the serial clock rests at the polarity level of whichever device `dev_sel` currently names.

Top module: `spi_sclk_cs_gen`

## Requirements
- R1: Serial clock toggles are exactly 256/RATE functional cycles apart for power-of-two RATE codes 1 to 128. RATE is bits 31:24 of the device's timing word.
- R2: A RATE code of zero behaves as code 1, giving toggles 256 cycles apart.
- R3: In the timing word, bits 23:16 are the setup count S, bits 15:8 the hold count H and bits 7:0 the gap count D. A write with `param_we` high stores `param_wdata` as the word of device `param_addr`.
- R4: For a transfer of at least one bit, the first clock toggle comes S+1+256/RATE cycles after the select goes low.
- R5: A transfer of N bits produces exactly 2N serial clock toggles, all while the select is low, and the clock ends at the device's polarity level.
- R6: The select stays low for H+1 cycles, counting from the cycle of the last clock toggle, and then goes high.
- R7: `ready` returns high D+1 cycles after the select goes high. A `start` pulse while `ready` is low is ignored and does not begin a later transfer.
- R8: Only the select bit of the device named by `dev_sel` at the accepted start goes low. At most one select is low at any time.
- R9: While idle, `sclk` equals the polarity bit of the device on `dev_sel`, with one cycle of latency. Polarity and phase bits are written per device through the mode port.
- R10: With phase bit 0, `capture_stb` marks odd-numbered (leading) toggles and `launch_stb` marks even-numbered toggles except the last. With phase bit 1, `launch_stb` marks leading toggles and `capture_stb` marks trailing toggles. Each strobe is one cycle wide, falls in the same cycle as its toggle, and appears at no other time.
- R11: A transfer with a bit count of zero makes no clock toggles and holds the select low for S+H+2 cycles.
- R12: The timing word and mode bits are captured when a transfer is accepted. Writes to them during the transfer do not change that transfer.
- R13: After reset, all selects are high, `sclk` is 0, `ready` is 1, both strobes are 0, and every stored timing word and mode bit is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| param_we | input | 1 | Write strobe for a device timing word |
| param_addr | input | 3 | Device whose timing word is written |
| param_wdata | input | 32 | Timing word: rate, setup, hold, gap |
| mode_we | input | 1 | Write strobe for a device's clock-mode bits |
| mode_addr | input | 3 | Device whose mode bits are written |
| mode_cpol | input | 1 | Clock polarity to store |
| mode_cpha | input | 1 | Clock phase to store |
| start | input | 1 | One-cycle request to begin a transfer (accepted when ready) |
| dev_sel | input | 3 | Device for the transfer, and for the idle clock level |
| xfer_bits | input | 16 | Number of bits in the transfer |
| ready | output | 1 | High when a new transfer may be started |
| sclk | output | 1 | Serial clock |
| cs_n | output | 8 | Active-low device selects, one per device |
| launch_stb | output | 1 | One-cycle mark of a data launch edge |
| capture_stb | output | 1 | One-cycle mark of a data capture edge |

## Verification
The bench measures every transfer cycle by cycle. It counts the setup, toggle spacing, hold and gap intervals, so a counter that ends one cycle early or late, or an accumulator that wraps at 512 instead of 256, shows up as a wrong interval length. Each of the four polarity/phase combinations is run, so a design that swaps the launch and capture strobes, or emits a launch after the final edge, disagrees on the strobe pattern. A zero rate code and a zero bit count are run: a design without the code clamp never toggles and hangs, and a design without the zero-bit path runs the clock forever. A start issued during the gap, and timing writes made in the middle of a transfer, check that a busy block neither queues the request nor picks up the new values.

// File: rtl/sclkgen_pkg.sv
package sclkgen_pkg;

    localparam int FIELD_W = 8;
    localparam int WORD_W  = 4 * FIELD_W;

    // Field order follows the word layout: rate in the top byte, gap in the bottom.
    typedef struct packed {
        logic [FIELD_W-1:0] rate;
        logic [FIELD_W-1:0] setup;
        logic [FIELD_W-1:0] hold;
        logic [FIELD_W-1:0] gap;
    } dev_param_t;

    typedef struct packed {
        logic cpol;
        logic cpha;
    } dev_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CLOCK,
        ST_HOLD,
        ST_GAP
    } seq_state_t;

    // A zero code would never carry out of the accumulator; run it as the slowest code.
    function automatic logic [FIELD_W-1:0] eff_rate(input logic [FIELD_W-1:0] code);
        return (code == '0) ? FIELD_W'(1) : code;
    endfunction

    function automatic dev_param_t unpack_param(input logic [WORD_W-1:0] word);
        return dev_param_t'(word);
    endfunction

endpackage

// File: rtl/sclkgen_cfg_store.sv
module sclkgen_cfg_store
    import sclkgen_pkg::*;
#(
    parameter int NDEV  = 8,
    parameter int SEL_W = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              param_we,
    input  logic [SEL_W-1:0]  param_addr,
    input  logic [WORD_W-1:0] param_wdata,
    input  logic              mode_we,
    input  logic [SEL_W-1:0]  mode_addr,
    input  logic              mode_cpol,
    input  logic              mode_cpha,
    input  logic [SEL_W-1:0]  rd_sel,
    output dev_param_t        rd_param,
    output dev_mode_t         rd_mode
);

    dev_param_t param_tbl [NDEV];
    dev_mode_t  mode_tbl  [NDEV];

    for (genvar g = 0; g < NDEV; g++) begin : g_dev
        logic       p_hit;
        logic       m_hit;
        dev_param_t p_q;
        dev_mode_t  m_q;

        assign p_hit = param_we && (param_addr == SEL_W'(g));
        assign m_hit = mode_we  && (mode_addr  == SEL_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                p_q <= '0;
                m_q <= '0;
            end else begin
                if (p_hit) begin
                    p_q <= unpack_param(param_wdata);
                end
                if (m_hit) begin
                    m_q.cpol <= mode_cpol;
                    m_q.cpha <= mode_cpha;
                end
            end
        end

        assign param_tbl[g] = p_q;
        assign mode_tbl[g]  = m_q;
    end

    always_comb begin
        rd_param = '0;
        rd_mode  = '0;
        for (int i = 0; i < NDEV; i++) begin
            if (rd_sel == SEL_W'(i)) begin
                rd_param = param_tbl[i];
                rd_mode  = mode_tbl[i];
            end
        end
    end

endmodule

// File: rtl/sclkgen_rate_acc.sv
module sclkgen_rate_acc #(
    parameter int ACC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [ACC_W-1:0] rate,
    output logic             wrap
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    assign sum  = {1'b0, acc_q} + {1'b0, rate};
    assign wrap = run && sum[ACC_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (!run) begin
            acc_q <= '0;
        end else begin
            acc_q <= sum[ACC_W-1:0];
        end
    end

endmodule

// File: rtl/sclkgen_seq.sv
module sclkgen_seq
    import sclkgen_pkg::*;
#(
    parameter int NDEV   = 8,
    parameter int BITS_W = 16,
    parameter int SEL_W  = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [SEL_W-1:0]   dev_sel,
    input  logic [BITS_W-1:0]  xfer_bits,
    input  dev_param_t         sel_param,
    input  dev_mode_t          sel_mode,
    input  logic               wrap,
    output logic               run,
    output logic [FIELD_W-1:0] rate,
    output logic               ready,
    output logic               sclk,
    output logic [NDEV-1:0]    cs_n,
    output logic               launch_stb,
    output logic               capture_stb
);

    localparam int EDGE_W = BITS_W + 1;
    localparam logic [EDGE_W-1:0]  EDGE_ONE = EDGE_W'(1);
    localparam logic [FIELD_W-1:0] CNT_ONE  = FIELD_W'(1);

    seq_state_t         state_q;
    logic [FIELD_W-1:0] cnt_q;
    logic [EDGE_W-1:0]  edges_q;
    logic [BITS_W-1:0]  bits_q;
    dev_param_t         cur_q;
    dev_mode_t          mode_q;
    logic               sclk_q;
    logic [NDEV-1:0]    cs_n_q;
    logic               launch_q;
    logic               cap_q;

    logic               leading;
    logic               last_edge;

    // The toggle about to happen is odd-numbered when an even count has been made so far.
    assign leading   = ~edges_q[0];
    assign last_edge = wrap && ((edges_q + EDGE_ONE) == {bits_q, 1'b0});

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            edges_q  <= '0;
            bits_q   <= '0;
            cur_q    <= '0;
            mode_q   <= '0;
            sclk_q   <= 1'b0;
            cs_n_q   <= '1;
            launch_q <= 1'b0;
            cap_q    <= 1'b0;
        end else begin
            launch_q <= 1'b0;
            cap_q    <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    sclk_q <= sel_mode.cpol;
                    if (start) begin
                        cur_q        <= sel_param;
                        cur_q.rate   <= eff_rate(sel_param.rate);
                        mode_q       <= sel_mode;
                        bits_q       <= xfer_bits;
                        cnt_q        <= '0;
                        cs_n_q       <= '1;
                        cs_n_q[dev_sel] <= 1'b0;
                        state_q      <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (cnt_q == cur_q.setup) begin
                        cnt_q   <= '0;
                        edges_q <= '0;
                        state_q <= (bits_q == '0) ? ST_HOLD : ST_CLOCK;
                    end else begin
                        cnt_q <= cnt_q + CNT_ONE;
                    end
                end
                ST_CLOCK: begin
                    if (wrap) begin
                        sclk_q  <= ~sclk_q;
                        edges_q <= edges_q + EDGE_ONE;
                        if (mode_q.cpha) begin
                            launch_q <= leading;
                            cap_q    <= ~leading;
                        end else begin
                            cap_q    <= leading;
                            launch_q <= ~leading && !last_edge;
                        end
                        if (last_edge) begin
                            cnt_q   <= '0;
                            state_q <= ST_HOLD;
                        end
                    end
                end
                ST_HOLD: begin
                    if (cnt_q == cur_q.hold) begin
                        cnt_q   <= '0;
                        cs_n_q  <= '1;
                        state_q <= ST_GAP;
                    end else begin
                        cnt_q <= cnt_q + CNT_ONE;
                    end
                end
                ST_GAP: begin
                    if (cnt_q == cur_q.gap) begin
                        cnt_q   <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + CNT_ONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign run         = (state_q == ST_CLOCK);
    assign rate        = cur_q.rate;
    assign ready       = (state_q == ST_IDLE);
    assign sclk        = sclk_q;
    assign cs_n        = cs_n_q;
    assign launch_stb  = launch_q;
    assign capture_stb = cap_q;

endmodule

// File: rtl/spi_sclk_cs_gen.sv
module spi_sclk_cs_gen
    import sclkgen_pkg::*;
#(
    parameter int NDEV   = 8,
    parameter int BITS_W = 16,
    parameter int SEL_W  = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              param_we,
    input  logic [SEL_W-1:0]  param_addr,
    input  logic [WORD_W-1:0] param_wdata,
    input  logic              mode_we,
    input  logic [SEL_W-1:0]  mode_addr,
    input  logic              mode_cpol,
    input  logic              mode_cpha,
    input  logic              start,
    input  logic [SEL_W-1:0]  dev_sel,
    input  logic [BITS_W-1:0] xfer_bits,
    output logic              ready,
    output logic              sclk,
    output logic [NDEV-1:0]   cs_n,
    output logic              launch_stb,
    output logic              capture_stb
);

    dev_param_t         sel_param;
    dev_mode_t          sel_mode;
    logic               acc_run;
    logic               acc_wrap;
    logic [FIELD_W-1:0] acc_rate;

    sclkgen_cfg_store #(
        .NDEV  (NDEV),
        .SEL_W (SEL_W)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .param_we    (param_we),
        .param_addr  (param_addr),
        .param_wdata (param_wdata),
        .mode_we     (mode_we),
        .mode_addr   (mode_addr),
        .mode_cpol   (mode_cpol),
        .mode_cpha   (mode_cpha),
        .rd_sel      (dev_sel),
        .rd_param    (sel_param),
        .rd_mode     (sel_mode)
    );

    sclkgen_rate_acc #(
        .ACC_W (FIELD_W)
    ) u_acc (
        .clk  (clk),
        .rst  (rst),
        .run  (acc_run),
        .rate (acc_rate),
        .wrap (acc_wrap)
    );

    sclkgen_seq #(
        .NDEV   (NDEV),
        .BITS_W (BITS_W),
        .SEL_W  (SEL_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .dev_sel     (dev_sel),
        .xfer_bits   (xfer_bits),
        .sel_param   (sel_param),
        .sel_mode    (sel_mode),
        .wrap        (acc_wrap),
        .run         (acc_run),
        .rate        (acc_rate),
        .ready       (ready),
        .sclk        (sclk),
        .cs_n        (cs_n),
        .launch_stb  (launch_stb),
        .capture_stb (capture_stb)
    );

endmodule

// File: rtl/spi_sclk_cs_gen_chk.sv
module spi_sclk_cs_gen_chk #(
    parameter int NDEV   = 8,
    parameter int BITS_W = 16,
    parameter int SEL_W  = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [SEL_W-1:0]  dev_sel,
    input logic [BITS_W-1:0] xfer_bits,
    input logic              ready,
    input logic              sclk,
    input logic [NDEV-1:0]   cs_n,
    input logic              launch_stb,
    input logic              capture_stb
);

    localparam logic [NDEV-1:0] SEL_ONE = NDEV'(1);

    p_single_select_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    p_start_selects_r8: assert property (@(posedge clk) disable iff (rst)
        (start && ready) |=> (~cs_n == (SEL_ONE << $past(dev_sel))));

    p_strobe_on_edge_r10: assert property (@(posedge clk) disable iff (rst)
        (launch_stb || capture_stb) |-> (sclk != $past(sclk)));

    p_strobe_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        !(launch_stb && capture_stb));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        ready |-> ((&cs_n) && !launch_stb && !capture_stb));

    p_edges_inside_select_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(ready) && (sclk != $past(sclk))) |-> !(&cs_n));

    p_zero_bits_no_clock_r11: assert property (@(posedge clk) disable iff (rst)
        (start && ready && (xfer_bits == '0)) |=> !launch_stb && !capture_stb);

endmodule

bind spi_sclk_cs_gen spi_sclk_cs_gen_chk #(
    .NDEV   (NDEV),
    .BITS_W (BITS_W),
    .SEL_W  (SEL_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .dev_sel     (dev_sel),
    .xfer_bits   (xfer_bits),
    .ready       (ready),
    .sclk        (sclk),
    .cs_n        (cs_n),
    .launch_stb  (launch_stb),
    .capture_stb (capture_stb)
);

// File: tb/sim_spi_sclk_cs_gen.sv
module sim_spi_sclk_cs_gen;

    localparam int CLK_PERIOD = 10;
    localparam int NDEV       = 8;
    localparam int BITS_W     = 16;
    localparam int SEL_W      = 3;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst;
    logic              param_we;
    logic [SEL_W-1:0]  param_addr;
    logic [31:0]       param_wdata;
    logic              mode_we;
    logic [SEL_W-1:0]  mode_addr;
    logic              mode_cpol;
    logic              mode_cpha;
    logic              start;
    logic [SEL_W-1:0]  dev_sel;
    logic [BITS_W-1:0] xfer_bits;
    logic              ready;
    logic              sclk;
    logic [NDEV-1:0]   cs_n;
    logic              launch_stb;
    logic              capture_stb;

    int n_checks = 0;
    int n_fail   = 0;

    spi_sclk_cs_gen #(
        .NDEV   (NDEV),
        .BITS_W (BITS_W)
    ) u0 (
        .clk         (clk),
        .rst         (rst),
        .param_we    (param_we),
        .param_addr  (param_addr),
        .param_wdata (param_wdata),
        .mode_we     (mode_we),
        .mode_addr   (mode_addr),
        .mode_cpol   (mode_cpol),
        .mode_cpha   (mode_cpha),
        .start       (start),
        .dev_sel     (dev_sel),
        .xfer_bits   (xfer_bits),
        .ready       (ready),
        .sclk        (sclk),
        .cs_n        (cs_n),
        .launch_stb  (launch_stb),
        .capture_stb (capture_stb)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_param(input int dev, input int rate, input int s, input int h, input int d);
        @(negedge clk);
        param_we    = 1'b1;
        param_addr  = SEL_W'(dev);
        param_wdata = {8'(rate), 8'(s), 8'(h), 8'(d)};
        @(negedge clk);
        param_we    = 1'b0;
    endtask

    task automatic write_mode(input int dev, input bit cpol, input bit cpha);
        @(negedge clk);
        mode_we   = 1'b1;
        mode_addr = SEL_W'(dev);
        mode_cpol = cpol;
        mode_cpha = cpha;
        @(negedge clk);
        mode_we   = 1'b0;
    endtask

    // Runs one transfer and measures every interval against the expected timing.
    task automatic xfer_measure(input int dev, input int nbits, input int rate, input int s,
                                input int h, input int d, input bit cpol, input bit cpha);
        int  half;
        int  pre = 0, tog = 0, last_i = 0, post = 0, gap = 0, lowtot = 0;
        int  bad_int = 0, bad_stb = 0, other_low = 0, off_sel = 0;
        bit  prev, cur_low, lead, exp_l, exp_c;
        half = 256 / ((rate == 0) ? 1 : rate);
        @(negedge clk);
        dev_sel   = SEL_W'(dev);
        xfer_bits = BITS_W'(nbits);
        @(negedge clk);
        chk("R9", "idle clock level before start", int'(sclk), int'(cpol));
        chk("R7", "ready before start", int'(ready), 1);
        prev  = sclk;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            if (ready) break;
            cur_low = !cs_n[dev];
            if ((cs_n | (NDEV'(1) << dev)) != '1) other_low++;
            if (sclk !== prev) begin
                tog++;
                if (tog > 1 && (i - last_i) != half) bad_int++;
                last_i = i;
                lead  = (tog % 2) == 1;
                exp_l = cpha ? lead : (!lead && tog != 2 * nbits);
                exp_c = cpha ? !lead : lead;
                if (launch_stb !== exp_l || capture_stb !== exp_c) bad_stb++;
                if (!cur_low) off_sel++;
            end else if (launch_stb || capture_stb) begin
                bad_stb++;
            end
            prev = sclk;
            if (cur_low) begin
                lowtot++;
                if (tog == 0) pre++;
                if (nbits > 0 && tog == 2 * nbits) post++;
            end else if (lowtot > 0) begin
                gap++;
            end
            @(negedge clk);
        end
        chk("R7", "ready returned", int'(ready), 1);
        chk("R5", "toggle count", tog, 2 * nbits);
        chk("R5", "toggles outside select", off_sel, 0);
        chk("R5", "final clock level", int'(sclk), int'(cpol));
        chk("R8", "other selects low", other_low, 0);
        chk("R10", "strobe mismatches", bad_stb, 0);
        chk("R7", "gap cycles", gap, d + 1);
        if (nbits > 0) begin
            chk("R1", "toggle spacing errors", bad_int, 0);
            chk("R4", "select low before first toggle", pre, s + 1 + half);
            chk("R6", "hold cycles from last toggle", post, h + 1);
        end else begin
            chk("R11", "select low cycles with zero bits", lowtot, s + h + 2);
        end
    endtask

    task automatic t_reset();
        chk("R13", "ready after reset", int'(ready), 1);
        chk("R13", "cs_n after reset", int'(cs_n), 255);
        chk("R13", "sclk after reset", int'(sclk), 0);
        chk("R13", "launch after reset", int'(launch_stb), 0);
        chk("R13", "capture after reset", int'(capture_stb), 0);
    endtask

    // Device 6 is never written: its word is zero, so rate code 0 acts as 1 (R2, R13).
    task automatic t_default_dev();
        xfer_measure(6, 1, 0, 0, 0, 0, 1'b0, 1'b0);
    endtask

    // R3 field layout: distinct setup, hold and gap values show up as distinct intervals.
    task automatic t_mode0();
        write_param(0, 128, 2, 3, 4);
        write_mode(0, 1'b0, 1'b0);
        xfer_measure(0, 3, 128, 2, 3, 4, 1'b0, 1'b0);
    endtask

    task automatic t_mode1();
        write_param(2, 64, 1, 2, 1);
        write_mode(2, 1'b0, 1'b1);
        xfer_measure(2, 4, 64, 1, 2, 1, 1'b0, 1'b1);
    endtask

    task automatic t_mode2();
        write_param(7, 1, 5, 1, 2);
        write_mode(7, 1'b1, 1'b0);
        xfer_measure(7, 1, 1, 5, 1, 2, 1'b1, 1'b0);
    endtask

    task automatic t_mode3();
        write_param(5, 32, 0, 0, 0);
        write_mode(5, 1'b1, 1'b1);
        xfer_measure(5, 2, 32, 0, 0, 0, 1'b1, 1'b1);
    endtask

    task automatic t_zero_bits();
        write_param(3, 16, 3, 4, 2);
        write_mode(3, 1'b0, 1'b0);
        xfer_measure(3, 0, 16, 3, 4, 2, 1'b0, 1'b0);
    endtask

    // R7: a start during the gap must be dropped, not held for later.
    task automatic t_busy_start();
        int low3 = 0;
        int late = 0;
        write_param(1, 128, 0, 0, 6);
        write_mode(1, 1'b0, 1'b0);
        @(negedge clk);
        dev_sel   = 3'd1;
        xfer_bits = 16'd1;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (cs_n[1]) break;
            @(negedge clk);
        end
        dev_sel = 3'd3;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (ready) break;
            if (!cs_n[3]) low3++;
            @(negedge clk);
        end
        for (int i = 0; i < 4; i++) begin
            if (!ready || cs_n != '1) late++;
            @(negedge clk);
        end
        chk("R7", "select 3 low from ignored start", low3, 0);
        chk("R7", "cycles busy after ignored start", late, 0);
    endtask

    // R12: rewriting the active device's word mid-transfer leaves the transfer as it began.
    task automatic t_latch();
        write_param(4, 128, 1, 1, 1);
        write_mode(4, 1'b0, 1'b0);
        fork
            xfer_measure(4, 3, 128, 1, 1, 1, 1'b0, 1'b0);
            begin
                repeat (4) @(negedge clk);
                write_param(4, 8, 9, 9, 9);
                write_mode(4, 1'b1, 1'b1);
            end
        join
        chk("R12", "transfer completed with old timing", int'(ready), 1);
    endtask

    task automatic t_idle_level();
        write_mode(6, 1'b1, 1'b0);
        @(negedge clk);
        dev_sel = 3'd6;
        @(negedge clk);
        chk("R9", "idle level follows device 6", int'(sclk), 1);
        dev_sel = 3'd0;
        @(negedge clk);
        chk("R9", "idle level follows device 0", int'(sclk), 0);
        chk("R9", "no select while idle", int'(cs_n), 255);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", WATCHDOG, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst         = 1'b1;
        param_we    = 1'b0;
        param_addr  = '0;
        param_wdata = '0;
        mode_we     = 1'b0;
        mode_addr   = '0;
        mode_cpol   = 1'b0;
        mode_cpha   = 1'b0;
        start       = 1'b0;
        dev_sel     = '0;
        xfer_bits   = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_default_dev();
        t_mode0();
        t_mode1();
        t_mode2();
        t_mode3();
        t_zero_bits();
        t_busy_start();
        t_latch();
        t_idle_level();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule